// File: doc/BRIEF.md
# Polarity Correlation Analyser

This block measures how closely two single-bit waveforms track each other across a set of time offsets. Typical inputs are the sign bits produced by comparators watching an analogue response and its reference. One input, the probe bit `sigA`, is delayed through a tapped shift line. For every tap, a counter records how often the delayed probe bit equals the undelayed reference bit `sigB`. This gives a sign-only estimate of the cross-correlation at each lag, all lags in parallel.

A measurement starts with a single-cycle start pulse, which clears every counter and the delay line. The window then runs for a fixed number of qualified samples, and a done flag rises when it ends. While done is set, the counts are shifted out serially, one bit per read strobe. Any normalisation or further analysis is left to the consumer of the serial stream.

Top module: `pol_corr_top`

## Requirements
- R1: After reset, `busy`, `done` and `dataOut` are all 0.
- R2: A start pulse accepted while no window is running does three things on that edge: it clears all lag counters to 0 and all delay-line bits to 0, it drops `done`, and it raises `busy`. The window counts only the samples that come after the start cycle.
- R3: A sample is qualified when `busy` is 1 and `sampleEn` is 1. On each qualified sample, `sigA` enters the delay line. Lag k (k = 0..15) compares `sigB` with the value of `sigA` from k+1 qualified samples earlier, where cleared bits count as 0.
- R4: A window holds exactly 8191 qualified samples. Cycles with `sampleEn` low do not advance it. On the edge that takes the last sample, `busy` falls and `done` rises.
- R5: On a qualified sample, the counter of lag k increases by one when its tap bit equals `sigB` (XNOR = 1). Otherwise it holds. Counters are 13 bits wide and never wrap, since 8191 is their maximum.
- R6: A start pulse while `busy` is 1 is ignored, and the running window continues unchanged.
- R7: While `done` is 1, `dataOut` shows the current readout bit. Words go out lag 0 first, and each 13-bit word goes out MSB first. Each `readEn` cycle advances one bit. After 208 bits the pointer returns to lag 0 MSB. While `done` is 0, `dataOut` is 0.
- R8: `readEn` while `done` is 0 has no effect, so readout after a window starts at lag 0 MSB.
- R9: `done` stays at 1 until the next start pulse. A start from the done state begins a fresh window as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Begins a measurement when idle or done |
| sampleEn | input | 1 | Qualifies the current clock as a sample |
| sigA | input | 1 | Probe sign bit, passed through the delay line |
| sigB | input | 1 | Reference sign bit, undelayed |
| readEn | input | 1 | Advances the serial readout by one bit |
| busy | output | 1 | Window in progress |
| done | output | 1 | Window complete, counts readable |
| dataOut | output | 1 | Serial count bit |

## Verification
The bench applies constant agreement, where lag k must end at 8191-(k+1). It also applies constant disagreement, where lag k must end at k+1. Both cases expose a delay line that is off by one tap, that keeps stale history across windows, or that is not cleared to zero. A random pass with gaps in `sampleEn` catches a window that counts raw clocks instead of samples. In the same pass, a start pulse mid-window would restart the count and shift every result, and read strobes during the window would make the readout begin at the wrong bit. Reading past the last word checks that the pointer wraps to lag 0 MSB and does not stick or run into an undefined slot.

// File: rtl/pca_pkg.sv
package pca_pkg;
  typedef struct packed {
    logic clearAll;
    logic sampleStb;
    logic readStb;
  } pcaStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } pcaState_t;
endpackage

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
#(
  parameter int WINDOW = 8191
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        sampleEn,
  input  logic        readEn,
  output pcaStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  pcaState_t        state;
  logic [WIN_W-1:0] winCnt;
  logic             lastSample;

  always_comb begin
    strobes.clearAll  = startPulse && (state != ST_RUN);
    strobes.sampleStb = (state == ST_RUN) && sampleEn;
    strobes.readStb   = (state == ST_DONE) && readEn && !startPulse;
    lastSample        = strobes.sampleStb && (winCnt == WIN_W'(WINDOW - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      winCnt <= '0;
    end else if (strobes.clearAll) begin
      state  <= ST_RUN;
      winCnt <= '0;
    end else if (strobes.sampleStb) begin
      winCnt <= winCnt + 1'b1;
      if (lastSample) state <= ST_DONE;
    end
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

  assert_window_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    lastSample |=> (done && !busy));

  assert_sample_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sampleStb && !lastSample) |=> (winCnt == $past(winCnt) + 1'b1));

  assert_window_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastSample) |=> busy);

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> done);
endmodule

// File: rtl/pca_datapath.sv
module pca_datapath
  import pca_pkg::*;
#(
  parameter int NUM_LAGS = 16,
  parameter int CNT_W    = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  pcaStrobes_t strobes,
  input  logic        sigA,
  input  logic        sigB,
  output logic        rawBit
);
  localparam int LAG_W = (NUM_LAGS > 1) ? $clog2(NUM_LAGS) : 1;
  localparam int BIT_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

  logic [NUM_LAGS-1:0] shReg;
  logic [NUM_LAGS-1:0] agree;
  logic [CNT_W-1:0]    lagCnt [NUM_LAGS];
  logic [LAG_W-1:0]    lagIdx;
  logic [BIT_W-1:0]    bitIdx;
  logic [BIT_W-1:0]    bitSel;
  logic [CNT_W-1:0]    curWord;

  // delay line: bit k holds sigA from k+1 qualified samples ago
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  shReg <= '0;
    else if (strobes.clearAll)  shReg <= '0;
    else if (strobes.sampleStb) shReg <= {shReg[NUM_LAGS-2:0], sigA};
  end

  for (genvar k = 0; k < NUM_LAGS; k++) begin : g_lag
    assign agree[k] = ~(shReg[k] ^ sigB);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                lagCnt[k] <= '0;
      else if (strobes.clearAll)                lagCnt[k] <= '0;
      else if (strobes.sampleStb && agree[k])   lagCnt[k] <= lagCnt[k] + 1'b1;
    end

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.clearAll |=> ((lagCnt[k] == $past(lagCnt[k])) ||
                             (lagCnt[k] == $past(lagCnt[k]) + 1'b1)));

    assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clearAll |=> (lagCnt[k] == '0));
  end

  // serial readout pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lagIdx <= '0;
      bitIdx <= '0;
    end else if (strobes.clearAll) begin
      lagIdx <= '0;
      bitIdx <= '0;
    end else if (strobes.readStb) begin
      if (bitIdx == BIT_W'(CNT_W - 1)) begin
        bitIdx <= '0;
        lagIdx <= (lagIdx == LAG_W'(NUM_LAGS - 1)) ? '0 : lagIdx + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    bitSel  = BIT_W'(CNT_W - 1) - bitIdx;
    curWord = lagCnt[lagIdx];
    rawBit  = curWord[bitSel];
  end

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sampleStb |=> (shReg[0] == $past(sigA)));

  assert_line_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (shReg == '0));

  assert_read_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readStb && lagIdx == LAG_W'(NUM_LAGS - 1) && bitIdx == BIT_W'(CNT_W - 1))
      |=> (lagIdx == '0 && bitIdx == '0));

  assert_read_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.readStb && !strobes.clearAll) |=> ($stable(lagIdx) && $stable(bitIdx)));
endmodule

// File: rtl/pol_corr_top.sv
module pol_corr_top
  import pca_pkg::*;
#(
  parameter int NUM_LAGS = 16,
  parameter int CNT_W    = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic startPulse,
  input  logic sampleEn,
  input  logic sigA,
  input  logic sigB,
  input  logic readEn,
  output logic busy,
  output logic done,
  output logic dataOut
);
  localparam int WINDOW = (2 ** CNT_W) - 1;

  pcaStrobes_t strobes;
  logic        rawBit;

  pca_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .sampleEn(sampleEn),
    .readEn(readEn), .strobes(strobes), .busy(busy), .done(done)
  );

  pca_datapath #(.NUM_LAGS(NUM_LAGS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sigA(sigA), .sigB(sigB),
    .rawBit(rawBit)
  );

  assign dataOut = done & rawBit;

  assert_out_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !dataOut);
endmodule

// File: tb/sim_pol_corr_top.sv
`timescale 1ns/1ps
module sim_pol_corr_top;
  localparam int LAGS = 16;
  localparam int CW   = 13;
  localparam int WIN  = 8191;

  logic clk = 0, rstN = 0;
  logic startPulse = 0, sampleEn = 0, sigA = 0, sigB = 0, readEn = 0;
  logic busy, done, dataOut;

  int nTests = 0, nFail = 0;

  pol_corr_top u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .sampleEn(sampleEn),
    .sigA(sigA), .sigB(sigB), .readEn(readEn),
    .busy(busy), .done(done), .dataOut(dataOut)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  bit mRun, mDone;
  int mWin, mLag, mBit;
  int mCnt [LAGS];
  bit hist [$];
  int qual;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mDone = 0; mWin = 0; mLag = 0; mBit = 0;
      foreach (mCnt[k]) mCnt[k] = 0;
      hist.delete();
      for (int k = 0; k < LAGS; k++) hist.push_back(1'b0);
    end else begin
      if (mRun && sampleEn) qual++;
      if (startPulse && !mRun) begin
        mRun = 1; mDone = 0; mWin = 0; mLag = 0; mBit = 0; qual = 0;
        foreach (mCnt[k]) mCnt[k] = 0;
        hist.delete();
        for (int k = 0; k < LAGS; k++) hist.push_back(1'b0);
      end else if (mRun && sampleEn) begin
        for (int k = 0; k < LAGS; k++) if (hist[k] == sigB) mCnt[k]++;
        hist.push_front(sigA);
        void'(hist.pop_back());
        mWin++;
        if (mWin == WIN) begin mRun = 0; mDone = 1; end
      end else if (mDone && readEn) begin
        mBit++;
        if (mBit == CW) begin mBit = 0; mLag = (mLag + 1) % LAGS; end
      end
    end
  end

  function automatic bit expBit();
    if (!mDone) return 1'b0;
    return 1'((mCnt[mLag] >> (CW - 1 - mBit)) & 1);
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) if (rstN) begin
    chk(busy == mRun, "R4 busy", busy, mRun);
    chk(done == mDone, "R4/R9 done", done, mDone);
    chk(dataOut == expBit(), "R7 dataOut", dataOut, expBit());
  end

  task automatic doStart();
    @(negedge clk); startPulse = 1;
    @(negedge clk); startPulse = 0;
    chk(busy == 1 && done == 0, "R2/R9 start", {busy, done}, 2);
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
    sampleEn = 0;
  endtask

  // reads all words; words[k] gets lag k; checks wrap to lag 0 MSB afterwards
  task automatic readAll(output int words [LAGS]);
    int w;
    for (int k = 0; k < LAGS; k++) begin
      w = 0;
      for (int b = 0; b < CW; b++) begin
        @(negedge clk);
        w = (w << 1) | int'(dataOut);
        readEn = 1;
      end
      words[k] = w;
    end
    @(negedge clk);
    chk(dataOut == 1'((words[0] >> (CW - 1)) & 1), "R7 wrap", dataOut, (words[0] >> (CW - 1)) & 1);
    readEn = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int words [LAGS];
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && dataOut == 0, "R1 reset", {busy, done, dataOut}, 0);
    rstN = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && dataOut == 0, "R1 after release", {busy, done, dataOut}, 0);

    // random window: gaps in sampleEn, start and reads mid-window
    doStart();
    for (int i = 0; ; i++) begin
      @(negedge clk);
      if (done) break;
      sampleEn   = ($urandom % 4) != 0;
      sigA       = 1'($urandom);
      sigB       = 1'($urandom);
      startPulse = (i == 100);
      readEn     = (i >= 200 && i < 210);
      if (i == 102) chk(busy == 1, "R6 start ignored", busy, 1);
    end
    sampleEn = 0; startPulse = 0; readEn = 0;
    chk(qual == WIN, "R4/R6 window length", qual, WIN);
    readAll(words);
    chk(words[0] == mCnt[0], "R8 first word lag0", words[0], mCnt[0]);
    for (int k = 1; k < LAGS; k++)
      chk(words[k] == mCnt[k], "R5 random word", words[k], mCnt[k]);

    // done holds while idle
    repeat (20) @(negedge clk);
    chk(done == 1 && busy == 0, "R9 done held", {busy, done}, 1);

    // constant agreement: lag k must be 8191-(k+1)
    doStart();
    sigA = 1; sigB = 1; sampleEn = 1;
    waitDone();
    readAll(words);
    for (int k = 0; k < LAGS; k++)
      chk(words[k] == WIN - (k + 1), "R3/R5 agree count", words[k], WIN - (k + 1));

    // constant disagreement: only cleared taps agree, lag k must be k+1
    doStart();
    sigA = 1; sigB = 0; sampleEn = 1;
    waitDone();
    readAll(words);
    for (int k = 0; k < LAGS; k++)
      chk(words[k] == k + 1, "R2/R3 disagree count", words[k], k + 1);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule